// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is the device-side control logic of a three-wire serial EEPROM. A host drives chip select, a serial clock and a data line. The block looks for a start bit, then collects a two-bit opcode, an address and, when the command needs it, write data. It then runs the command against an internal register-array memory. That memory holds `2**(WORD_AW+1)` bytes. A word-size select input decides whether the host sees 16-bit words or single bytes. The serial inputs are sampled with the system clock, so the serial clock must be several system clocks slower than `clk`.

Reads return one dummy zero followed by data, MSB first. If the host keeps clocking, the block streams the following locations and wraps to address zero. Modifying commands are word write, word erase, whole-array erase and whole-array fill. They take effect only when a write-enable latch is set and the program-enable input is high. Each one starts a self-timed busy period of `WR_CYCLES` system clocks. While that period runs, the host can raise chip select and poll DO for ready/busy.

The serial link is a plain shift interface with no back-pressure. The host owns the pace of every bit, and the block never stalls it. Control and status pins are plain levels.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A command begins only at the first rising serial-clock edge that finds both chip select and DI high. Edges with DI low before that edge are skipped, and activity while chip select is low has no effect.
- R2: The two bits after the start bit are the opcode: 10 reads, 01 writes a location, 11 erases a location, and 00 selects a special command. For 00, the two most significant address bits choose it: 11 enables modification, 00 disables it, 10 erases the whole array and 01 fills the whole array with the following data word. The other address bits are ignored.
- R3: With `org_wide` high, a location is a 16-bit word and the address has WORD_AW bits. With it low, a location is a byte and the address has WORD_AW+1 bits. Byte 2k is the upper half of word k and byte 2k+1 is the lower half.
- R4: At the serial-clock edge that delivers the last address bit of a read, DO is enabled and driven 0. Each following edge puts out the next data bit, MSB first.
- R5: If the host keeps clocking after a read word, the next location follows with no dummy bit. After the last location the read wraps to 0.
- R6: After reset the array reads all ones, DO is released and modification is disabled. Write, erase, whole-array erase and whole-array fill are ignored until an enable command, and a disable command blocks them again.
- R7: A modifying command is ignored when `prog_en` is low at the moment chip select falls.
- R8: A command whose bits were not all clocked in before chip select falls has no effect and starts no busy period.
- R9: An accepted modifying command changes the array and starts a busy period of exactly WR_CYCLES system clocks. Start bits are ignored during that period.
- R10: At the next rise of chip select after an accepted modifying command, DO shows status: 0 while busy and 1 once ready. Status stays on until chip select falls or a new start bit is accepted.
- R11: DO is enabled only while read data or status is being output, and it is released within three system clocks after chip select falls.
- R12: Erase sets the addressed location to all ones. Whole-array erase sets every byte to 8'hFF. Whole-array fill writes the data to every location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| ser_cs | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_di | input | 1 | Serial data in |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| prog_en | input | 1 | 1 allows array modification |
| ser_do | output | 1 | Serial data out value |
| ser_do_en | output | 1 | Output enable for DO; 0 means high impedance |

## Verification
A wrong decode or address-width state shows up at the port as the wrong data on DO. It is visible at the first data bit of the next read of the disturbed location, or at the dummy-zero slot when the read framing is off by a bit. A stuck write-enable latch or a skipped gate on program enable shows at the next chip-select rise: a status window opens or fails to open, and a read-back a few hundred clocks later returns the wrong value. A busy counter of the wrong length moves the point where status flips from 0 to 1, and a front end that is not idle during the busy period turns status into read data on DO.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    CMD_READ,
    CMD_WRITE,
    CMD_ERASE,
    CMD_EWEN,
    CMD_EWDS,
    CMD_ERAL,
    CMD_WRAL
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } mw_fe_state_e;

  typedef enum logic [2:0] {
    AOP_NONE,
    AOP_WRITE,
    AOP_ERASE,
    AOP_ERAL,
    AOP_WRAL
  } mw_arr_op_e;

  function automatic mw_cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sub);
    mw_cmd_e c;
    case (op)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        case (sub)
          2'b11:   c = CMD_EWEN;
          2'b10:   c = CMD_ERAL;
          2'b01:   c = CMD_WRAL;
          default: c = CMD_EWDS;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mw_serial_front.sv
module mw_serial_front
  import mw_eeprom_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_cs,
  input  logic                 ser_clk,
  input  logic                 ser_di,
  input  logic                 org_wide,
  input  logic                 busy,
  input  logic [15:0]          rd_data,
  output logic [WORD_AW:0]     rd_addr,
  output logic                 rd_on,
  output logic                 rd_bit,
  output logic                 cmd_go,
  output mw_cmd_e              cmd,
  output logic [WORD_AW:0]     cmd_addr,
  output logic [15:0]          cmd_data,
  output logic                 cmd_wide,
  output logic                 start_acc,
  output logic                 cs_rise,
  output logic                 cs_fall,
  output logic                 cs_lvl,
  output logic                 cs_prev,
  output mw_fe_state_e         fe_state
);

  localparam int AW_MAX = WORD_AW + 1;
  localparam int HW     = AW_MAX + 2;
  localparam int CW     = $clog2(HW + 17);

  logic cs_s, cs_p, ck_s, ck_p, di_s;
  logic edge_hit;
  logic [HW-2:0] sreg;
  logic [HW-1:0] hdr_next;
  logic [15:0]   dreg;
  logic [15:0]   oreg;
  logic          oload;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hlen;
  logic [CW-1:0] dlen;
  logic [1:0]    dec_op;
  logic [1:0]    dec_sub;
  logic [AW_MAX-1:0] dec_addr;
  mw_cmd_e       dec_cmd;
  mw_fe_state_e  state;

  // synchronise the serial pins to the system clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 1'b0;
      cs_p <= 1'b0;
      ck_s <= 1'b0;
      ck_p <= 1'b0;
      di_s <= 1'b0;
    end else begin
      cs_s <= ser_cs;
      cs_p <= cs_s;
      ck_s <= ser_clk;
      ck_p <= ck_s;
      di_s <= ser_di;
    end
  end

  assign edge_hit = ck_s & ~ck_p & cs_s;
  assign cs_rise  = cs_s & ~cs_p;
  assign cs_fall  = cs_p & ~cs_s;
  assign cs_lvl   = cs_s;
  assign cs_prev  = cs_p;
  assign fe_state = state;

  assign hdr_next = {sreg, di_s};
  assign hlen     = org_wide ? CW'(WORD_AW + 2) : CW'(WORD_AW + 3);
  assign dlen     = cmd_wide ? CW'(16) : CW'(8);

  always_comb begin
    if (org_wide) begin
      dec_op   = hdr_next[WORD_AW+1:WORD_AW];
      dec_sub  = hdr_next[WORD_AW-1:WORD_AW-2];
      dec_addr = {1'b0, hdr_next[WORD_AW-1:0]};
    end else begin
      dec_op   = hdr_next[WORD_AW+2:WORD_AW+1];
      dec_sub  = hdr_next[WORD_AW:WORD_AW-1];
      dec_addr = hdr_next[WORD_AW:0];
    end
    dec_cmd = decode_cmd(dec_op, dec_sub);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sreg      <= '0;
      dreg      <= '0;
      oreg      <= '0;
      oload     <= 1'b0;
      cnt       <= '0;
      rd_addr   <= '0;
      rd_on     <= 1'b0;
      rd_bit    <= 1'b0;
      cmd_go    <= 1'b0;
      cmd       <= CMD_EWDS;
      cmd_addr  <= '0;
      cmd_wide  <= 1'b1;
      start_acc <= 1'b0;
    end else begin
      cmd_go    <= 1'b0;
      start_acc <= 1'b0;
      if (cs_fall) begin
        cmd_go <= (state == ST_DONE);
        state  <= ST_IDLE;
        rd_on  <= 1'b0;
        oload  <= 1'b0;
      end else if (edge_hit) begin
        case (state)
          ST_IDLE: begin
            if (di_s && !busy) begin
              state     <= ST_HDR;
              cnt       <= '0;
              sreg      <= '0;
              start_acc <= 1'b1;
            end
          end
          ST_HDR: begin
            sreg <= hdr_next[HW-2:0];
            cnt  <= cnt + CW'(1);
            if (cnt == hlen - CW'(1)) begin
              cnt      <= '0;
              cmd      <= dec_cmd;
              cmd_addr <= dec_addr;
              cmd_wide <= org_wide;
              if (dec_cmd == CMD_READ) begin
                state   <= ST_READ;
                rd_on   <= 1'b1;
                rd_bit  <= 1'b0;
                rd_addr <= dec_addr;
                oload   <= 1'b1;
              end else if (dec_cmd == CMD_WRITE || dec_cmd == CMD_WRAL) begin
                state <= ST_DATA;
                dreg  <= '0;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          ST_DATA: begin
            dreg <= {dreg[14:0], di_s};
            cnt  <= cnt + CW'(1);
            if (cnt == dlen - CW'(1)) state <= ST_DONE;
          end
          ST_READ: begin
            rd_bit <= oreg[15];
            oreg   <= {oreg[14:0], 1'b0};
            cnt    <= cnt + CW'(1);
            if (cnt == dlen - CW'(1)) begin
              cnt   <= '0;
              oload <= 1'b1;
              if (cmd_wide)
                rd_addr <= {1'b0, rd_addr[WORD_AW-1:0] + WORD_AW'(1)};
              else
                rd_addr <= rd_addr + AW_MAX'(1);
            end
          end
          default: ;
        endcase
      end else if (oload) begin
        oreg  <= rd_data;
        oload <= 1'b0;
      end
    end
  end

  assign cmd_data = dreg;

endmodule

// File: rtl/mw_prog_ctrl.sv
module mw_prog_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int WORD_AW   = 10,
  parameter int WR_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  mw_cmd_e          cmd,
  input  logic [WORD_AW:0] cmd_addr,
  input  logic [15:0]      cmd_data,
  input  logic             cmd_wide,
  input  logic             prog_en,
  input  logic             cs_rise,
  input  logic             cs_fall,
  input  logic             start_acc,
  output logic             wen,
  output logic             busy,
  output logic             stat_on,
  output mw_arr_op_e       arr_op,
  output logic [WORD_AW:0] arr_addr,
  output logic [15:0]      arr_data,
  output logic             arr_wide
);

  localparam int BW = $clog2(WR_CYCLES + 1);

  logic [BW-1:0] busy_cnt;
  logic          wr_class;
  logic          launch;
  logic          pend;
  mw_arr_op_e    op_map;

  always_comb begin
    case (cmd)
      CMD_WRITE: op_map = AOP_WRITE;
      CMD_ERASE: op_map = AOP_ERASE;
      CMD_ERAL:  op_map = AOP_ERAL;
      CMD_WRAL:  op_map = AOP_WRAL;
      default:   op_map = AOP_NONE;
    endcase
  end

  assign wr_class = (op_map != AOP_NONE);
  assign launch   = cmd_go && wr_class && wen && prog_en;
  assign busy     = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen      <= 1'b0;
      busy_cnt <= '0;
      pend     <= 1'b0;
      stat_on  <= 1'b0;
      arr_op   <= AOP_NONE;
      arr_addr <= '0;
      arr_data <= '0;
      arr_wide <= 1'b1;
    end else begin
      if (cmd_go && cmd == CMD_EWEN) wen <= 1'b1;
      else if (cmd_go && cmd == CMD_EWDS) wen <= 1'b0;

      if (launch) busy_cnt <= BW'(WR_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - BW'(1);

      if (launch) pend <= 1'b1;
      else if (cs_rise) pend <= 1'b0;

      if (cs_fall || start_acc) stat_on <= 1'b0;
      else if (cs_rise && pend) stat_on <= 1'b1;

      arr_op <= launch ? op_map : AOP_NONE;
      if (launch) begin
        arr_addr <= cmd_addr;
        arr_data <= cmd_data;
        arr_wide <= cmd_wide;
      end
    end
  end

endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_eeprom_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mw_arr_op_e       op,
  input  logic             wide,
  input  logic [WORD_AW:0] addr,
  input  logic [15:0]      wdata,
  input  logic [WORD_AW:0] rd_addr,
  input  logic             rd_wide,
  output logic [15:0]      rd_data
);

  localparam int AW_MAX = WORD_AW + 1;
  localparam int NB     = 2 ** AW_MAX;

  logic [7:0] mem [NB];
  logic [AW_MAX-1:0] hi_idx, lo_idx, rhi_idx, rlo_idx;

  assign hi_idx  = {addr[WORD_AW-1:0], 1'b0};
  assign lo_idx  = {addr[WORD_AW-1:0], 1'b1};
  assign rhi_idx = {rd_addr[WORD_AW-1:0], 1'b0};
  assign rlo_idx = {rd_addr[WORD_AW-1:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      case (op)
        AOP_WRITE: begin
          if (wide) begin
            mem[hi_idx] <= wdata[15:8];
            mem[lo_idx] <= wdata[7:0];
          end else begin
            mem[addr] <= wdata[7:0];
          end
        end
        AOP_ERASE: begin
          if (wide) begin
            mem[hi_idx] <= 8'hFF;
            mem[lo_idx] <= 8'hFF;
          end else begin
            mem[addr] <= 8'hFF;
          end
        end
        AOP_ERAL: begin
          for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
        end
        AOP_WRAL: begin
          for (int i = 0; i < NB; i++)
            mem[i] <= (wide && (i % 2) == 0) ? wdata[15:8] : wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  assign rd_data = rd_wide ? {mem[rhi_idx], mem[rlo_idx]} : {mem[rd_addr], 8'h00};

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_eeprom_pkg::*;
#(
  parameter int WORD_AW   = 10,
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_cs,
  input  logic ser_clk,
  input  logic ser_di,
  input  logic org_wide,
  input  logic prog_en,
  output logic ser_do,
  output logic ser_do_en
);

  logic             busy;
  logic [15:0]      rd_data;
  logic [WORD_AW:0] rd_addr;
  logic             rd_on;
  logic             rd_bit;
  logic             cmd_go;
  mw_cmd_e          cmd;
  logic [WORD_AW:0] cmd_addr;
  logic [15:0]      cmd_data;
  logic             cmd_wide;
  logic             start_acc;
  logic             cs_rise;
  logic             cs_fall;
  logic             cs_lvl;
  logic             cs_prev;
  mw_fe_state_e     fe_state;
  logic             wen;
  logic             stat_on;
  mw_arr_op_e       arr_op;
  logic [WORD_AW:0] arr_addr;
  logic [15:0]      arr_data;
  logic             arr_wide;

  mw_serial_front #(.WORD_AW(WORD_AW)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_cs    (ser_cs),
    .ser_clk   (ser_clk),
    .ser_di    (ser_di),
    .org_wide  (org_wide),
    .busy      (busy),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .rd_on     (rd_on),
    .rd_bit    (rd_bit),
    .cmd_go    (cmd_go),
    .cmd       (cmd),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_wide  (cmd_wide),
    .start_acc (start_acc),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .cs_lvl    (cs_lvl),
    .cs_prev   (cs_prev),
    .fe_state  (fe_state)
  );

  mw_prog_ctrl #(.WORD_AW(WORD_AW), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .cmd       (cmd),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_wide  (cmd_wide),
    .prog_en   (prog_en),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .start_acc (start_acc),
    .wen       (wen),
    .busy      (busy),
    .stat_on   (stat_on),
    .arr_op    (arr_op),
    .arr_addr  (arr_addr),
    .arr_data  (arr_data),
    .arr_wide  (arr_wide)
  );

  mw_array #(.WORD_AW(WORD_AW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (arr_op),
    .wide    (arr_wide),
    .addr    (arr_addr),
    .wdata   (arr_data),
    .rd_addr (rd_addr),
    .rd_wide (cmd_wide),
    .rd_data (rd_data)
  );

  assign ser_do    = stat_on ? ~busy : rd_bit;
  assign ser_do_en = stat_on | rd_on;

endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk
  import mw_eeprom_pkg::*;
#(
  parameter int WR_CYCLES = 5000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_lvl,
  input logic         cs_prev,
  input logic         ser_do,
  input logic         ser_do_en,
  input logic         busy,
  input logic         rd_on,
  input logic         wen,
  input logic         cmd_go,
  input mw_arr_op_e   arr_op,
  input mw_fe_state_e fe_state
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 32'd1;
    else run_len <= '0;
  end

  assert_do_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && !cs_prev) |-> !ser_do_en);

  assert_dummy_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_on) |-> (ser_do_en && !ser_do));

  assert_front_idle_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fe_state == ST_IDLE));

  assert_cycle_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == WR_CYCLES));

  assert_op_starts_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_op != AOP_NONE) |-> busy);

  assert_locked_no_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_op != AOP_NONE) |-> wen);

  assert_enable_by_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(cmd_go));

  assert_status_busy_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_do_en && !rd_on && busy) |-> !ser_do);

endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_lvl    (cs_lvl),
  .cs_prev   (cs_prev),
  .ser_do    (ser_do),
  .ser_do_en (ser_do_en),
  .busy      (busy),
  .rd_on     (rd_on),
  .wen       (wen),
  .cmd_go    (cmd_go),
  .arr_op    (arr_op),
  .fe_state  (fe_state)
);

// File: tb/mw_eeprom_slave_bench.sv
`timescale 1ns/100ps
module mw_eeprom_slave_bench;

  localparam int WAW  = 4;
  localparam int WRC  = 200;
  localparam int H    = 4;
  localparam int NB   = 2 ** (WAW + 1);
  localparam int NW   = 2 ** WAW;

  logic clk = 1'b0;
  logic rst_n, cs, sck, di, org, pen;
  logic dout, doen;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_mem [NB];
  logic ref_wen;

  always #2.5 clk = ~clk;

  mw_eeprom_slave #(.WORD_AW(WAW), .WR_CYCLES(WRC)) u_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .ser_cs(cs), .ser_clk(sck), .ser_di(di),
    .org_wide(org), .prog_en(pen), .ser_do(dout), .ser_do_en(doen)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sbit(input logic b);
    di = b; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1; tick(4);
  endtask

  task automatic cs_dn();
    cs = 1'b0; sck = 1'b0; di = 1'b0; tick(4);
  endtask

  function automatic int aw();
    return org ? WAW : WAW + 1;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  function automatic logic [15:0] exp_loc(input int a);
    if (org) return {ref_mem[2*a], ref_mem[2*a+1]};
    return {8'h00, ref_mem[a]};
  endfunction

  task automatic hdr(input logic [1:0] op, input int a);
    sbit(1'b1); sbit(op[1]); sbit(op[0]);
    for (int i = aw() - 1; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    for (int i = dw() - 1; i >= 0; i--) sbit(d[i]);
  endtask

  task automatic get_loc(output logic [15:0] w);
    w = '0;
    for (int i = 0; i < dw(); i++) begin
      sbit(1'b0);
      w = {w[14:0], dout};
    end
  endtask

  // end a modifying command and check the status window
  task automatic finish_prog(input logic expect_launch, input string req);
    cs_dn();
    cs_up();
    if (expect_launch) begin
      chk({req, " R10 busy"}, {doen, dout}, 2'b10);
      tick(WRC + 10);
      chk({req, " R10 ready"}, {doen, dout}, 2'b11);
      cs_dn();
      chk({req, " R11 release"}, doen, 1'b0);
    end else begin
      chk({req, " no status"}, doen, 1'b0);
      cs_dn();
    end
  endtask

  task automatic write_loc(input int a, input logic [15:0] d, input string req);
    logic go;
    go = ref_wen && pen;
    cs_up(); hdr(2'b01, a); send_data(d);
    finish_prog(go, req);
    if (go) begin
      if (org) begin ref_mem[2*a] = d[15:8]; ref_mem[2*a+1] = d[7:0]; end
      else ref_mem[a] = d[7:0];
    end
  endtask

  task automatic special(input logic [1:0] sub, input logic [15:0] d, input string req);
    logic go;
    int a;
    a = int'(sub) << (aw() - 2);
    cs_up(); hdr(2'b00, a);
    if (sub == 2'b01) send_data(d);
    go = (sub == 2'b10 || sub == 2'b01) && ref_wen && pen;
    finish_prog(go, req);
    if (sub == 2'b11) ref_wen = 1'b1;
    if (sub == 2'b00) ref_wen = 1'b0;
    if (go) begin
      for (int i = 0; i < NB; i++) begin
        if (sub == 2'b10) ref_mem[i] = 8'hFF;
        else ref_mem[i] = (org && (i % 2) == 0) ? d[15:8] : d[7:0];
      end
    end
  endtask

  task automatic read_check(input int a, input string req);
    logic [15:0] w;
    cs_up(); hdr(2'b10, a);
    chk({req, " R4 dummy"}, {doen, dout}, 2'b10);
    get_loc(w);
    chk(req, w, exp_loc(a));
    cs_dn();
  endtask

  task automatic seq_check(input int start, input int count, input string req);
    logic [15:0] w;
    int n;
    n = org ? NW : NB;
    cs_up(); hdr(2'b10, start);
    chk({req, " R4 dummy"}, {doen, dout}, 2'b10);
    for (int k = 0; k < count; k++) begin
      get_loc(w);
      chk(req, w, exp_loc((start + k) % n));
    end
    cs_dn();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic ok;
    logic [15:0] w;
    rst_n = 1'b0; cs = 1'b0; sck = 1'b0; di = 1'b0; org = 1'b1; pen = 1'b1;
    ref_wen = 1'b0;
    for (int i = 0; i < NB; i++) ref_mem[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    chk("R11 reset DO released", doen, 1'b0);
    read_check(3, "R6 erased after reset");

    // modification locked after reset
    write_loc(2, 16'h1234, "R6 locked write");
    read_check(2, "R6 locked write readback");

    special(2'b11, 16'h0, "R2 enable");

    // sweep every word with an arithmetic pattern
    for (int a = 0; a < NW; a++)
      write_loc(a, 16'((a * 16'h1357) ^ 16'hA5C3), "R2 write sweep");
    seq_check(0, NW + 2, "R5 sequential wrap x16");

    // byte view of the same array
    org = 1'b0;
    seq_check(0, NB + 2, "R3 byte sweep with wrap");
    write_loc(5, 16'h003C, "R3 byte write");
    read_check(31, "R3 top byte address");
    org = 1'b1;
    read_check(2, "R3 word holds byte 5 as low half");

    // leading zero edges before the start bit
    cs_up(); sbit(1'b0); sbit(1'b0); sbit(1'b0);
    hdr(2'b10, 7);
    chk("R1 dummy after leading zeros", {doen, dout}, 2'b10);
    get_loc(w);
    chk("R1 read after leading zeros", w, exp_loc(7));
    cs_dn();

    // a full write frame clocked with chip select low
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    for (int i = 0; i < WAW; i++) sbit(1'b0);
    for (int i = 0; i < 16; i++) sbit(1'b0);
    tick(4);
    chk("R1 DO idle with CS low", doen, 1'b0);
    read_check(0, "R1 no write with CS low");

    // command cut short
    cs_up(); hdr(2'b01, 4);
    for (int i = 0; i < 10; i++) sbit(1'b0);
    cs_dn(); cs_up();
    chk("R8 no status after cut command", doen, 1'b0);
    cs_dn();
    read_check(4, "R8 cut write left word");

    // erase one word
    cs_up(); hdr(2'b11, 6);
    finish_prog(1'b1, "R12 erase");
    ref_mem[12] = 8'hFF; ref_mem[13] = 8'hFF;
    read_check(6, "R12 erased word");

    // program enable low
    pen = 1'b0;
    write_loc(7, 16'h1234, "R7 blocked write");
    pen = 1'b1;
    read_check(7, "R7 word unchanged");

    // start bits ignored while busy
    cs_up(); hdr(2'b01, 8); send_data(16'hBEEF);
    cs_dn(); cs_up();
    chk("R10 busy poll", {doen, dout}, 2'b10);
    hdr(2'b10, 8);
    chk("R9 still status during busy", {doen, dout}, 2'b10);
    tick(WRC);
    chk("R9 ready after busy", {doen, dout}, 2'b11);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sbit(1'b0);
      if (dout !== 1'b1 || doen !== 1'b1) ok = 1'b0;
    end
    chk("R9 ignored start gave no read data", ok, 1'b1);
    cs_dn();
    ref_mem[16] = 8'hBE; ref_mem[17] = 8'hEF;
    read_check(8, "R9 write landed");

    // disable again
    special(2'b00, 16'h0, "R6 disable");
    write_loc(9, 16'h5555, "R6 write after disable");
    read_check(9, "R6 word unchanged after disable");
    special(2'b11, 16'h0, "R2 re-enable");

    // bulk erase and fill
    special(2'b10, 16'h0, "R12 bulk erase");
    seq_check(0, NW, "R12 all ones");
    special(2'b01, 16'hC3A5, "R12 bulk fill x16");
    seq_check(0, NW, "R12 fill x16");
    org = 1'b0;
    special(2'b01, 16'h005A, "R12 bulk fill x8");
    seq_check(0, NB, "R12 fill x8");
    org = 1'b1;

    summary();
  end

endmodule